// File: doc/BRIEF.md
# Feedback-Driven Thread Count Estimator

This block recommends how many threads a parallel kernel should use on a multicore chip. A `start` pulse opens a training window of a fixed number of cycles. During the window, single-cycle strobes from a running thread mark entry to and exit from the critical section, and mark each bus transfer the thread issues. The block counts the cycles spent inside the critical section, the cycles spent outside it, and the transfers.

When the window closes, a compute phase derives two limits. The first comes from contention on the critical section: the integer square root of the ratio of outside time to inside time. The second comes from bandwidth: the configured total bus bandwidth (in transfers per training window) divided by the transfers one thread issued. The smaller of the two limits and the core count is presented on the output with a one-cycle done strobe. The block then stays in the execute phase, holding that value until a later start yields a new one.

All arithmetic runs on one sequential restoring divider and one bit-serial square-root unit, so a full estimate costs roughly two operand widths plus half a width of cycles after training ends.

Top module: `thread_count_estimator`

## Requirements
- R1: A `start` pulse while idle clears all three training counters and the critical-section flag, captures `total_bw_i`, and opens a window of exactly TRAIN_CYCLES cycles; a change to `total_bw_i` after that cycle does not affect the result.
- R2: A training cycle counts as inside the critical section when the flag was set at the start of that cycle, and as outside otherwise; `cs_enter_i` sets the flag, `cs_exit_i` clears it, and enter wins when both are high in the same cycle.
- R3: Every training cycle with `xfer_i` high adds one to the transfer count.
- R4: The inside, outside and transfer counters are ACC_W bits wide and hold at 2^ACC_W-1 instead of wrapping.
- R5: The synchronization limit is floor(sqrt(floor(outside/inside))), raised to 1 when it is 0, and equals NUM_CORES when the inside count is 0.
- R6: The bandwidth limit is floor(total/transfers), raised to 1 when it is 0, and equals NUM_CORES when the transfer count is 0.
- R7: The reported count is the minimum of the two limits and NUM_CORES, so it always lies in 1..NUM_CORES.
- R8: After reset the count reads 0 and `done_o` is low; `done_o` is high for exactly one cycle when a new count appears, and the count does not change in any other cycle.
- R9: A `start` pulse during training or computing is ignored: the window and the counters continue and the result is the one the uninterrupted run gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new training window (acted on only when idle) |
| cs_enter_i | input | 1 | Thread entered the critical section this cycle |
| cs_exit_i | input | 1 | Thread left the critical section this cycle |
| xfer_i | input | 1 | Thread issued one bus transfer this cycle |
| total_bw_i | input | ACC_W | Total bus bandwidth in transfers per training window |
| thread_cnt_o | output | clog2(NUM_CORES+1) | Recommended thread count |
| done_o | output | 1 | One-cycle strobe: a new count is on `thread_cnt_o` |

## Verification
The bound checker watches the invariants that hold on every cycle: the done strobe never lasts two cycles, the count moves only together with it and always lies between 1 and the core count, a counter that has reached its ceiling stays there, an inside cycle advances the inside counter by one, and a start during compute never sends the block back into training. Whether the number itself is right (the square root, the two quotients, the zero-divisor fallbacks, enter-over-exit priority, capture of the bandwidth at start and the ignoring of starts in mid-window) can only be shown by the bench, which sweeps inside lengths, transfer counts and bandwidth settings on a small configuration and recomputes each expected count arithmetically.

// File: rtl/thread_count_estimator.sv
module thread_count_estimator #(
  parameter int NUM_CORES    = 32,
  parameter int ACC_W        = 32,
  parameter int TRAIN_CYCLES = 4096
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           cs_enter_i,
  input  logic                           cs_exit_i,
  input  logic                           xfer_i,
  input  logic [ACC_W-1:0]               total_bw_i,
  output logic [$clog2(NUM_CORES+1)-1:0] thread_cnt_o,
  output logic                           done_o
);

  localparam int CNT_W  = $clog2(NUM_CORES+1);
  localparam int WIN_W  = $clog2(TRAIN_CYCLES);
  localparam int STEP_W = $clog2(ACC_W) + 1;
  localparam logic [ACC_W-1:0] CORES_W = ACC_W'(NUM_CORES);
  localparam logic [ACC_W-1:0] SQ_TOP  = ACC_W'(1) << (ACC_W-2);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_TRAIN = 3'd1;
  localparam logic [2:0] S_CSLD  = 3'd2;
  localparam logic [2:0] S_DIVCS = 3'd3;
  localparam logic [2:0] S_SQRT  = 3'd4;
  localparam logic [2:0] S_BWLD  = 3'd5;
  localparam logic [2:0] S_DIVBW = 3'd6;
  localparam logic [2:0] S_FIN   = 3'd7;

  logic [2:0]       state_q;
  logic             cs_q;
  logic [WIN_W-1:0] win_q;
  logic [ACC_W-1:0] in_q, out_q, xf_q, tbw_q;
  logic [ACC_W-1:0] rem_q, quo_q, dvs_q;
  logic [ACC_W-1:0] op_q, res_q, bit_q;
  logic [STEP_W-1:0] step_q;
  logic [ACC_W-1:0] ncs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  function automatic logic [ACC_W-1:0] sat_inc(input logic [ACC_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [ACC_W-1:0] lift(input logic [ACC_W-1:0] v);
    return (v == '0) ? ACC_W'(1) : v;
  endfunction

  logic [ACC_W:0]   rem_sh, diff;
  logic             div_ge;
  logic [ACC_W-1:0] rem_nx, quo_nx;
  assign rem_sh = {rem_q, quo_q[ACC_W-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};
  assign div_ge = ~diff[ACC_W];
  assign rem_nx = div_ge ? diff[ACC_W-1:0] : rem_sh[ACC_W-1:0];
  assign quo_nx = {quo_q[ACC_W-2:0], div_ge};

  logic [ACC_W-1:0] sq_trial, op_nx, res_nx;
  logic             sq_ge;
  assign sq_trial = res_q + bit_q;
  assign sq_ge    = op_q >= sq_trial;
  assign op_nx    = sq_ge ? op_q - sq_trial : op_q;
  assign res_nx   = sq_ge ? (res_q >> 1) + bit_q : res_q >> 1;

  logic [ACC_W-1:0] nbw_w, min_a, min_b;
  assign nbw_w = lift(quo_q);
  assign min_a = (ncs_q < nbw_w) ? ncs_q : nbw_w;
  assign min_b = (min_a < CORES_W) ? min_a : CORES_W;

  wire last_div  = step_q == STEP_W'(ACC_W-1);
  wire last_sqrt = step_q == STEP_W'(ACC_W/2-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cs_q    <= 1'b0;
      win_q   <= '0;
      in_q    <= '0;
      out_q   <= '0;
      xf_q    <= '0;
      tbw_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      op_q    <= '0;
      res_q   <= '0;
      bit_q   <= '0;
      step_q  <= '0;
      ncs_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          cs_q    <= 1'b0;
          win_q   <= '0;
          in_q    <= '0;
          out_q   <= '0;
          xf_q    <= '0;
          tbw_q   <= total_bw_i;
          state_q <= S_TRAIN;
        end
        S_TRAIN: begin
          cs_q <= cs_enter_i ? 1'b1 : (cs_exit_i ? 1'b0 : cs_q);
          if (cs_q) in_q <= sat_inc(in_q);
          else      out_q <= sat_inc(out_q);
          if (xfer_i) xf_q <= sat_inc(xf_q);
          if (win_q == WIN_W'(TRAIN_CYCLES-1)) state_q <= S_CSLD;
          else win_q <= win_q + 1'b1;
        end
        S_CSLD: begin
          if (in_q == '0) begin
            ncs_q   <= CORES_W;
            state_q <= S_BWLD;
          end else begin
            rem_q   <= '0;
            quo_q   <= out_q;
            dvs_q   <= in_q;
            step_q  <= '0;
            state_q <= S_DIVCS;
          end
        end
        S_DIVCS: begin
          rem_q  <= rem_nx;
          quo_q  <= quo_nx;
          step_q <= step_q + 1'b1;
          if (last_div) begin
            op_q    <= quo_nx;
            res_q   <= '0;
            bit_q   <= SQ_TOP;
            step_q  <= '0;
            state_q <= S_SQRT;
          end
        end
        S_SQRT: begin
          op_q   <= op_nx;
          res_q  <= res_nx;
          bit_q  <= bit_q >> 2;
          step_q <= step_q + 1'b1;
          if (last_sqrt) begin
            ncs_q   <= lift(res_nx);
            state_q <= S_BWLD;
          end
        end
        S_BWLD: begin
          if (xf_q == '0) begin
            quo_q   <= CORES_W;
            state_q <= S_FIN;
          end else begin
            rem_q   <= '0;
            quo_q   <= tbw_q;
            dvs_q   <= xf_q;
            step_q  <= '0;
            state_q <= S_DIVBW;
          end
        end
        S_DIVBW: begin
          rem_q  <= rem_nx;
          quo_q  <= quo_nx;
          step_q <= step_q + 1'b1;
          if (last_div) state_q <= S_FIN;
        end
        default: begin
          cnt_q   <= CNT_W'(min_b);
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  assign thread_cnt_o = cnt_q;
  assign done_o       = done_q;

endmodule

module thread_count_estimator_chk #(
  parameter int NUM_CORES = 32,
  parameter int ACC_W     = 32,
  parameter int CNT_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic [CNT_W-1:0] thread_cnt_o,
  input logic [2:0]       phase,
  input logic             cs_flag,
  input logic [ACC_W-1:0] acc_in,
  input logic [ACC_W-1:0] acc_xf
);
  localparam logic [ACC_W-1:0] TOP = '1;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thread_cnt_o != $past(thread_cnt_o)) |-> done_o);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (thread_cnt_o >= CNT_W'(1) && thread_cnt_o <= CNT_W'(NUM_CORES)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= 3'd2 && start_i) |=> phase != 3'd1);

  // R4
  in_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && acc_in == TOP) |=> acc_in == TOP);

  // R4
  xf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && acc_xf == TOP) |=> acc_xf == TOP);

  // R2
  in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && cs_flag && acc_in != TOP) |=> acc_in == $past(acc_in) + 1'b1);

endmodule

bind thread_count_estimator thread_count_estimator_chk #(
  .NUM_CORES(NUM_CORES), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .thread_cnt_o(thread_cnt_o), .phase(state_q), .cs_flag(cs_q),
  .acc_in(in_q), .acc_xf(xf_q)
);

// File: tb/sim_thread_count_estimator.sv
module sim_thread_count_estimator;
  localparam int CLK_PERIOD = 10;
  localparam int CORES = 8;
  localparam int AW    = 8;
  localparam int WIN   = 300;
  localparam int CW    = $clog2(CORES+1);
  localparam int TOP   = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, cs_enter_i = 1'b0, cs_exit_i = 1'b0, xfer_i = 1'b0;
  logic [AW-1:0] total_bw_i = '0;
  logic [CW-1:0] thread_cnt_o;
  logic done_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_count_estimator #(.NUM_CORES(CORES), .ACC_W(AW), .TRAIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_enter_i(cs_enter_i),
    .cs_exit_i(cs_exit_i), .xfer_i(xfer_i), .total_bw_i(total_bw_i),
    .thread_cnt_o(thread_cnt_o), .done_o(done_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int isqrt(input int v);
    int r = 0;
    while ((r+1)*(r+1) <= v) r++;
    return r;
  endfunction

  function automatic int sat(input int v);
    return (v > TOP) ? TOP : v;
  endfunction

  function automatic int expect_cnt(input int ins, input int outs, input int xf, input int tbw);
    int ncs, nbw, m;
    ncs = (ins == 0) ? CORES : isqrt(outs / ins);
    if (ncs == 0) ncs = 1;
    nbw = (xf == 0) ? CORES : tbw / xf;
    if (nbw == 0) nbw = 1;
    m = (ncs < nbw) ? ncs : nbw;
    return (m < CORES) ? m : CORES;
  endfunction

  // k: inside cycles (enter at cycle 0, exit at cycle k); x: transfer cycles
  task automatic run(input int k, input int x, input int tbw, input string tag,
                     input bit both0, input bit mid_start, input bit late_start,
                     input bit bw_change);
    int ins, outs, xf, e, got, held;
    total_bw_i = AW'(tbw);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      cs_enter_i = (k > 0 && i == 0);
      cs_exit_i  = (k > 0 && i == k) || (both0 && i == 0);
      xfer_i     = (i < x);
      start_i    = mid_start && (i == WIN/2);
      if (bw_change && i == 3) total_bw_i = ~AW'(tbw);
      @(negedge clk);
    end
    cs_enter_i = 1'b0; cs_exit_i = 1'b0; xfer_i = 1'b0; start_i = 1'b0;
    ins  = sat(k);
    outs = sat(WIN - k);
    xf   = sat(x);
    e = expect_cnt(ins, outs, xf, tbw);
    if (late_start) begin
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    got = 0;
    for (int w = 0; w < 200 && got == 0; w++) begin
      if (done_o) got = 1;
      else @(negedge clk);
    end
    chk(got == 1, "R8 done seen", got, 1);
    chk(int'(thread_cnt_o) == e, tag, int'(thread_cnt_o), e);
    held = int'(thread_cnt_o);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
    chk(int'(thread_cnt_o) == held, "R8 count held", int'(thread_cnt_o), held);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      total++; bad++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ks[11] = '{0, 1, 2, 3, 5, 10, 30, 100, 150, 200, 299};
    int xs[6]  = '{0, 1, 3, 7, 40, 299};
    int ts[4]  = '{0, 5, 40, 255};
    repeat (3) @(negedge clk);
    chk(thread_cnt_o == '0, "R8 reset count", int'(thread_cnt_o), 0);
    chk(done_o == 1'b0, "R8 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (ks[a]) foreach (xs[b]) foreach (ts[c])
      run(ks[a], xs[b], ts[c],
          (ks[a] == 0) ? "R5 inside zero" : ((xs[b] == 0) ? "R6 no transfers" : "R7 min of limits"),
          1'b0, 1'b0, 1'b0, 1'b0);

    // R2: enter and exit together at cycle 0, enter wins; exit at cycle 4
    run(4, 2, 200, "R2 enter priority", 1'b1, 1'b0, 1'b0, 1'b0);
    // R3: transfer count alone sets the limit
    run(0, 9, 27, "R3 transfer count", 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: counters saturate (outside 299 and transfers 299 both clip to 255)
    run(1, 299, 255, "R4 saturation", 1'b0, 1'b0, 1'b0, 1'b0);
    // R5: out/in below one still yields 1
    run(200, 0, 0, "R5 clamp to one", 1'b0, 1'b0, 1'b0, 1'b0);
    // R6: bandwidth quotient zero still yields 1
    run(0, 200, 5, "R6 clamp to one", 1'b0, 1'b0, 1'b0, 1'b0);
    // R1: bandwidth captured at start; a later change is not seen
    run(0, 10, 40, "R1 bandwidth captured", 1'b0, 1'b0, 1'b0, 1'b1);
    // R1: fresh start clears counters from the previous run
    run(0, 0, 0, "R1 counters cleared", 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: start in mid-training and during compute are ignored
    run(10, 5, 15, "R9 start in training", 1'b0, 1'b1, 1'b0, 1'b0);
    run(30, 1, 255, "R9 start in compute", 1'b0, 1'b0, 1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule